// File: doc/BRIEF.md
# Pulse-Width Serial Command Transmitter

This block sends 16-bit words over a single wire to a remote receiver. The timing of each pulse carries the meaning. Every bit occupies a cell that opens with a rising edge. The receiver samples the line twice, at two fixed delays after that edge. The first sample gives the bit value. The second sample tells the receiver whether more cells follow or whether this cell closes the transfer. The host presents a word and chooses whether the receiver should treat it as an address or as a command. A one-cycle load strobe starts the transfer. The block reports busy while the line is in use and pulses done when the line has settled.

The host can also ask the receiver for data with a separate request strobe. This produces one short low pulse and then a long high interval. When idle the line rests high. Before the first cell of a word transfer, the line is pulled low briefly so that the first cell has a clean rising edge.

The defaults assume a 40 MHz clock, so one cycle is 25 ns. The bit sample falls 5 cycles after each rising edge, the continue sample falls 10 cycles after it, and a cell lasts 16 cycles.

Top module: `pw_cmd_tx`

## Requirements
- R1: While reset is asserted and after it is released, the line is high, busy is low and done is low.
- R2: A load sampled while idle raises busy on the next cycle. The line is then held low for exactly 4 cycles before the first cell starts.
- R3: Each cell lasts 16 cycles and starts with the line high in its first cycle. The line is low in the last cycle of every cell except the final one, so each later cell opens with a rising edge.
- R4: Five cycles after a cell's first cycle, the line level equals the bit that cell carries: high for 1, low for 0.
- R5: Ten cycles after a cell's first cycle, the line is low in every cell except the final one. In the final cell it is high.
- R6: A transfer has 18 cells in this order. First comes a type cell carrying 1 for a command or 0 for an address. Next come word bits 15 down to 0, one per cell. Last comes a closing cell carrying 1.
- R7: After the final cell the line stays high. Done is high for exactly one cycle, the first cycle after the final cell, and busy is low from that same cycle.
- R8: A load strobe sampled while busy has no effect on the line, busy or done.
- R9: A data request sampled while idle, with no load in the same cycle, drives the line low for exactly 5 cycles and then high for 15 cycles with busy held. Done pulses in the cycle after that. A load and a request in the same idle cycle start a word transfer.
- R10: A data request sampled while busy has no effect on the line, busy or done.
- R11: Asserting the asynchronous reset during a transfer immediately forces the line high and busy and done low. The transfer is abandoned.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Start a word transfer (sampled when idle) |
| cmd_sel_i | input | 1 | 1 selects command, 0 selects address |
| word_i | input | 16 | Word to send, captured with load |
| dreq_i | input | 1 | Start a data request pulse (sampled when idle) |
| line_o | output | 1 | Serial line |
| busy_o | output | 1 | Transfer or request in progress |
| done_o | output | 1 | One-cycle pulse when the line has finished |

## Verification
The assertions assume that load and request are plain synchronous strobes that stay stable around each clock edge. They also assume that reset is the only way to interrupt a transfer. The stimulus meets this by changing inputs shortly after each rising edge. It holds each strobe for one cycle and leaves the data inputs free to change once the load has been taken. Reset is asserted only between clock edges, and only while the expected-value queue is empty.

// File: rtl/pw_cmd_tx_pkg.sv
package pw_cmd_tx_pkg;

   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_LEAD   = 3'd1,
      ST_CELL   = 3'd2,
      ST_REQ_LO = 3'd3,
      ST_REQ_HI = 3'd4
   } tx_state_e;

   function automatic int unsigned max_of2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/pw_cmd_wave.sv
module pw_cmd_wave #(
   parameter int unsigned CNT_W    = 5,
   parameter int unsigned HEAD_CYC = 2,
   parameter int unsigned DATA_AT  = 5,
   parameter int unsigned FLAG_AT  = 10,
   parameter int unsigned CELL_CYC = 16
) (
   input  logic [CNT_W-1:0] phase_i,
   input  logic             bit_i,
   input  logic             last_i,
   output logic             level_o
);

   localparam int unsigned FLAG_START = (DATA_AT + FLAG_AT + 1) / 2;

   if (HEAD_CYC < 1 || HEAD_CYC > DATA_AT) begin : g_bad_head
      $error("pw_cmd_wave: head width must lie in 1..DATA_AT");
   end
   if (FLAG_START <= DATA_AT || FLAG_START > FLAG_AT) begin : g_bad_flag
      $error("pw_cmd_wave: sample points too close");
   end
   if (CELL_CYC <= FLAG_AT + 1) begin : g_bad_cell
      $error("pw_cmd_wave: cell leaves no low gap after the flag");
   end

   always_comb begin
      if (phase_i < CNT_W'(HEAD_CYC)) begin
         level_o = 1'b1;
      end else if (phase_i < CNT_W'(FLAG_START)) begin
         level_o = bit_i;
      end else begin
         level_o = last_i;
      end
   end

endmodule

// File: rtl/pw_cmd_shifter.sv
module pw_cmd_shifter #(
   parameter int unsigned WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              capture_i,
   input  logic              advance_i,
   input  logic              type_i,
   input  logic [WORD_W-1:0] word_i,
   output logic              bit_o
);

   localparam int unsigned NCELLS = WORD_W + 2;

   logic [NCELLS-1:0] frame;
   logic [NCELLS-1:0] sh_q;

   assign frame[NCELLS-1] = type_i;
   assign frame[0]        = 1'b1;
   for (genvar k = 0; k < WORD_W; k++) begin : g_frame
      assign frame[k+1] = word_i[k];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q <= '0;
      end else if (capture_i) begin
         sh_q <= frame;
      end else if (advance_i) begin
         sh_q <= {sh_q[NCELLS-2:0], 1'b0};
      end
   end

   assign bit_o = sh_q[NCELLS-1];

endmodule

// File: rtl/pw_cmd_tx.sv
module pw_cmd_tx
   import pw_cmd_tx_pkg::*;
#(
   parameter int unsigned WORD_W       = 16,
   parameter int unsigned LEAD_CYC     = 4,
   parameter int unsigned HEAD_CYC     = 2,
   parameter int unsigned DATA_AT      = 5,
   parameter int unsigned FLAG_AT      = 10,
   parameter int unsigned CELL_CYC     = 16,
   parameter int unsigned REQ_LOW_CYC  = 5,
   parameter int unsigned REQ_HIGH_CYC = 15
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic              cmd_sel_i,
   input  logic [WORD_W-1:0] word_i,
   input  logic              dreq_i,
   output logic              line_o,
   output logic              busy_o,
   output logic              done_o
);

   localparam int unsigned NCELLS   = WORD_W + 2;
   localparam int unsigned IDX_W    = $clog2(NCELLS);
   localparam int unsigned MAX_SPAN = max_of2(max_of2(CELL_CYC, LEAD_CYC),
                                              max_of2(REQ_LOW_CYC, REQ_HIGH_CYC));
   localparam int unsigned CNT_W    = $clog2(MAX_SPAN + 1);

   if (WORD_W < 1) begin : g_bad_word
      $error("pw_cmd_tx: WORD_W must be at least 1");
   end
   if (LEAD_CYC < 1 || REQ_LOW_CYC < 1 || REQ_HIGH_CYC < 1) begin : g_bad_span
      $error("pw_cmd_tx: lead and request spans must be non-zero");
   end

   tx_state_e        state_q;
   logic [CNT_W-1:0] cnt;
   logic [IDX_W-1:0] idx_q;
   logic             done_q;
   logic             cur_bit;
   logic             final_cell;
   logic             cell_end;
   logic             capture;
   logic             cell_level;

   assign final_cell = (idx_q == IDX_W'(NCELLS - 1));
   assign cell_end   = (state_q == ST_CELL) && (cnt == CNT_W'(CELL_CYC - 1));
   assign capture    = (state_q == ST_IDLE) && load_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt     <= '0;
         idx_q   <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               cnt <= '0;
               if (load_i) begin
                  state_q <= ST_LEAD;
               end else if (dreq_i) begin
                  state_q <= ST_REQ_LO;
               end
            end
            ST_LEAD: begin
               if (cnt == CNT_W'(LEAD_CYC - 1)) begin
                  state_q <= ST_CELL;
                  cnt     <= '0;
                  idx_q   <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_CELL: begin
               if (cell_end) begin
                  cnt <= '0;
                  if (final_cell) begin
                     state_q <= ST_IDLE;
                     done_q  <= 1'b1;
                  end else begin
                     idx_q <= idx_q + 1'b1;
                  end
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_REQ_LO: begin
               if (cnt == CNT_W'(REQ_LOW_CYC - 1)) begin
                  state_q <= ST_REQ_HI;
                  cnt     <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_REQ_HI: begin
               if (cnt == CNT_W'(REQ_HIGH_CYC - 1)) begin
                  state_q <= ST_IDLE;
                  cnt     <= '0;
                  done_q  <= 1'b1;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   pw_cmd_shifter #(.WORD_W(WORD_W)) shifter_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .capture_i (capture),
      .advance_i (cell_end),
      .type_i    (cmd_sel_i),
      .word_i    (word_i),
      .bit_o     (cur_bit)
   );

   pw_cmd_wave #(
      .CNT_W    (CNT_W),
      .HEAD_CYC (HEAD_CYC),
      .DATA_AT  (DATA_AT),
      .FLAG_AT  (FLAG_AT),
      .CELL_CYC (CELL_CYC)
   ) wave_i (
      .phase_i (cnt),
      .bit_i   (cur_bit),
      .last_i  (final_cell),
      .level_o (cell_level)
   );

   always_comb begin
      unique case (state_q)
         ST_LEAD:   line_o = 1'b0;
         ST_CELL:   line_o = cell_level;
         ST_REQ_LO: line_o = 1'b0;
         default:   line_o = 1'b1;
      endcase
   end

   assign busy_o = (state_q != ST_IDLE);
   assign done_o = done_q;

endmodule

// File: rtl/pw_cmd_tx_chk.sv
module pw_cmd_tx_chk #(
   parameter int unsigned CNT_W    = 5,
   parameter int unsigned MAX_SPAN = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             load_i,
   input logic             dreq_i,
   input logic             line_o,
   input logic             busy_o,
   input logic             done_o,
   input logic [CNT_W-1:0] phase
);

   p_load_starts_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && load_i) |=> (busy_o && !line_o));

   p_phase_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
      phase < CNT_W'(MAX_SPAN));

   p_idle_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> line_o);

   p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   p_done_not_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o);

   p_busy_fall_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> done_o);

   p_dreq_starts_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && dreq_i && !load_i) |=> (busy_o && !line_o));

endmodule

bind pw_cmd_tx pw_cmd_tx_chk #(
   .CNT_W    (CNT_W),
   .MAX_SPAN (MAX_SPAN)
) chk_i (
   .clk    (clk),
   .rst_n  (rst_n),
   .load_i (load_i),
   .dreq_i (dreq_i),
   .line_o (line_o),
   .busy_o (busy_o),
   .done_o (done_o),
   .phase  (cnt)
);

// File: tb/pw_cmd_tx_tb_top.sv
`timescale 1ns/1ps
module pw_cmd_tx_tb_top;

   localparam int WORD_W   = 16;
   localparam int NCELLS   = WORD_W + 2;
   localparam int LEAD_CYC = 4;
   localparam int DATA_AT  = 5;
   localparam int FLAG_AT  = 10;
   localparam int CELL_CYC = 16;
   localparam int REQ_LO   = 5;
   localparam int REQ_HI   = 15;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              load_i = 1'b0;
   logic              cmd_sel_i = 1'b0;
   logic [WORD_W-1:0] word_i = '0;
   logic              dreq_i = 1'b0;
   logic              line_o, busy_o, done_o;

   int errors = 0;
   int checks = 0;

   // item: {care_line, line, busy, done}
   logic [3:0] exp_q[$];
   string      tag_q[$];

   always #10 clk = ~clk;

   pw_cmd_tx dut_i (
      .clk(clk), .rst_n(rst_n), .load_i(load_i), .cmd_sel_i(cmd_sel_i),
      .word_i(word_i), .dreq_i(dreq_i), .line_o(line_o), .busy_o(busy_o),
      .done_o(done_o)
   );

   task automatic push(input logic care, input logic ln, input logic bsy,
                       input logic dn, input string tag);
      exp_q.push_back({care, ln, bsy, dn});
      tag_q.push_back(tag);
   endtask

   task automatic check(input bit ok, input string tag, input string what,
                        input int act, input int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, expv);
      end
   endtask

   // monitor: pops one expected item per cycle while the queue has items
   always @(negedge clk) begin
      if (exp_q.size() > 0) begin
         logic [3:0] it;
         string      tg;
         it = exp_q.pop_front();
         tg = tag_q.pop_front();
         check((busy_o === it[1]) && (done_o === it[0]) &&
               (!it[3] || (line_o === it[2])), tg, "line/busy/done",
               {line_o, busy_o, done_o}, {it[2], it[1], it[0]});
      end
   end

   task automatic drain();
      while (exp_q.size() != 0) @(posedge clk);
   endtask

   // poke_at > 0: extra strobe that many cycles after the start (R8 load, R10 request)
   task automatic send_word(input logic cmd, input logic [WORD_W-1:0] w,
                            input bit with_dreq, input int poke_at, input bit poke_dreq);
      @(posedge clk); #1;
      push(1, 1, 0, 0, "R2");
      for (int i = 0; i < LEAD_CYC; i++) push(1, 0, 1, 0, "R2");
      for (int i = 0; i < NCELLS; i++) begin
         bit fin, b;
         fin = (i == NCELLS - 1);
         b   = (i == 0) ? cmd : (fin ? 1'b1 : w[WORD_W - i]);
         for (int t = 0; t < CELL_CYC; t++) begin
            if (t == 0)                push(1, 1, 1, 0, "R3");
            else if (t == DATA_AT)     push(1, b, 1, 0, (i == 0 || fin) ? "R6" : "R4");
            else if (t == FLAG_AT)     push(1, fin, 1, 0, "R5");
            else if (t == CELL_CYC-1)  push(1, fin, 1, 0, fin ? "R7" : "R3");
            else                       push(0, 0, 1, 0, "R6");
         end
      end
      push(1, 1, 0, 1, "R7");
      push(1, 1, 0, 0, "R7");
      load_i = 1'b1; cmd_sel_i = cmd; word_i = w; dreq_i = with_dreq;
      @(posedge clk); #1;
      load_i = 1'b0; dreq_i = 1'b0; cmd_sel_i = ~cmd; word_i = ~w;
      if (poke_at > 0) begin
         repeat (poke_at) @(posedge clk);
         #1;
         if (poke_dreq) dreq_i = 1'b1; else begin load_i = 1'b1; word_i = 16'h0F0F; end
         @(posedge clk); #1;
         dreq_i = 1'b0; load_i = 1'b0;
      end
      drain();
   endtask

   task automatic send_req(input int poke_at, input bit poke_dreq);
      @(posedge clk); #1;
      push(1, 1, 0, 0, "R9");
      for (int i = 0; i < REQ_LO; i++) push(1, 0, 1, 0, "R9");
      for (int i = 0; i < REQ_HI; i++) push(1, 1, 1, 0, "R9");
      push(1, 1, 0, 1, "R9");
      push(1, 1, 0, 0, "R9");
      dreq_i = 1'b1;
      @(posedge clk); #1;
      dreq_i = 1'b0;
      if (poke_at > 0) begin
         repeat (poke_at) @(posedge clk);
         #1;
         if (poke_dreq) dreq_i = 1'b1; else load_i = 1'b1;
         @(posedge clk); #1;
         dreq_i = 1'b0; load_i = 1'b0;
      end
      drain();
   endtask

   initial begin
      #5;
      check(line_o === 1'b1 && busy_o === 1'b0 && done_o === 1'b0, "R1",
            "in reset", {line_o, busy_o, done_o}, 3'b100);
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      check(line_o === 1'b1 && busy_o === 1'b0 && done_o === 1'b0, "R1",
            "after reset", {line_o, busy_o, done_o}, 3'b100);

      send_word(1'b0, 16'hA5C3, 1'b0, 0, 1'b0);      // address word
      send_word(1'b1, 16'h0001, 1'b0, 100, 1'b0);    // R8 load while busy
      send_word(1'b1, 16'hFFFF, 1'b1, 200, 1'b1);    // R9 priority, R10 request while busy
      send_word(1'b0, 16'h8000, 1'b0, 2, 1'b0);      // R8 load during lead-in
      send_req(3, 1'b0);                             // R9 request, R8 load during it
      send_req(10, 1'b1);                            // R10 request during request
      send_word(1'b1, 16'h0000, 1'b0, 0, 1'b0);

      // R11: reset in the middle of a transfer
      @(posedge clk); #1;
      load_i = 1'b1; cmd_sel_i = 1'b1; word_i = 16'h1234;
      @(posedge clk); #1;
      load_i = 1'b0;
      repeat (40) @(posedge clk);
      #3 rst_n = 1'b0;
      #1;
      check(line_o === 1'b1 && busy_o === 1'b0 && done_o === 1'b0, "R11",
            "async reset", {line_o, busy_o, done_o}, 3'b100);
      @(posedge clk); #1 rst_n = 1'b1;
      repeat (5) @(negedge clk);
      check(line_o === 1'b1 && busy_o === 1'b0 && done_o === 1'b0, "R11",
            "abandoned", {line_o, busy_o, done_o}, 3'b100);

      send_word(1'b0, 16'h5A5A, 1'b0, 0, 1'b0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule